// File: doc/BRIEF.md
# Quad DAC Serial Command Front End

This block is the two-wire serial slave that sits in front of a quad DAC register bank. It oversamples the bus clock and data lines with the system clock and finds start, repeated start and stop conditions. It answers a 7-bit address made of a fixed five-bit prefix and two strap pins. It also answers a write-only broadcast address. It recognises the high-speed master code, does not acknowledge it, and flags high-speed operation until the next stop or until a clear input is raised.

On writes, the block builds 24-bit frames from a command byte and two data bytes, and hands each finished frame to the register bank as a one-cycle pulse. When bit 22 of a frame (bit 6 of the command byte) is set, later byte pairs in the same transaction reuse the stored command byte. On reads, the block returns a 16-bit word taken from a readback port, high byte first. The data line is open-drain: the block only produces an output-enable that pulls the line low.

Top module: `dac_i2c_frontend`

## Requirements
- R1: An address byte whose upper seven bits equal 0b00011 followed by `strap[1:0]` is acknowledged by pulling SDA low during the ninth SCL pulse. Bit 0 of that byte selects read (1) or write (0).
- R2: The address byte 0x10 is acknowledged whatever the straps are. Frames written through it carry `frame_bcast`=1. The byte 0x11 (a read to the broadcast address) is not acknowledged.
- R3: An address byte whose upper five bits are 0b00001 is not acknowledged and sets `hs_mode`. `hs_mode` stays set across a repeated start, and clears on a stop or when `hs_clear` is high.
- R4: Any other address byte is not acknowledged. This includes 0x00 (general call), bytes whose top five bits are 0b11110 (ten-bit addressing), and own-address bytes with the wrong straps. The data bytes that follow it in that transaction get no acknowledge and produce no frames.
- R5: In an acknowledged write, every data byte is acknowledged. A command byte C, a byte M and a byte L give one `frame_valid` pulse, one cycle wide, with `frame_data` = {C, M, L}. C sits in bits 23:16.
- R6: If bit 6 of the command byte is 0, the byte after a completed frame is a new command byte. If it is 1, every further pair of bytes in the same transaction forms a frame with the same command byte.
- R7: A read to the own address returns `rd_word[15:8]` and then `rd_word[7:0]`, each most significant bit first. The word is captured at the end of the address acknowledge. After the second byte, the block releases SDA.
- R8: A frame that is not finished when a stop or a repeated start arrives is dropped, and no pulse is given for it.
- R9: SCL and SDA each pass through a two-flop synchroniser. A start is a falling SDA edge while SCL is high, and a stop is a rising SDA edge while SCL is high. After reset, `sda_oe`, `frame_valid` and `hs_mode` are 0.
- R10: `sda_oe` changes only while SCL is low, so the block never causes a start or stop condition itself.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| strap | input | 2 | Address strap pins, the two low address bits |
| hs_clear | input | 1 | Clears the high-speed flag |
| rd_word | input | 16 | Word returned on reads |
| frame_valid | output | 1 | One-cycle pulse when a frame is complete |
| frame_data | output | 24 | Completed frame, command byte in bits 23:16 |
| frame_bcast | output | 1 | The frame arrived through the broadcast address |
| hs_mode | output | 1 | A high-speed master code has been seen |

## Verification
The assertions assume that each SCL high and low phase lasts several system clocks longer than the synchroniser delay. They also assume that the master changes SDA while SCL is high only to make a start or stop, and never holds SCL low to stretch the clock. The stimulus models an open-drain bus with SCL quarter periods of 16 clocks. It moves SDA one quarter period after the SCL falling edge, and it samples the acknowledge and read bits in the middle of the SCL high phase. As a result, every change the block makes to `sda_oe`, which follows a falling SCL edge by a few clocks, has settled before the master looks at it.

// File: rtl/dac_i2c_pkg.sv
`timescale 1ns/1ps
package dac_i2c_pkg;

  typedef enum logic [1:0] {
    LK_IDLE,
    LK_RECV,
    LK_SEND,
    LK_WAIT
  } link_state_e;

  localparam logic [7:0] BCAST_WR_BYTE = 8'h10;
  localparam logic [4:0] HS_CODE_TOP   = 5'b00001;

  // write-only broadcast: the whole byte, R/W included, must match
  function automatic logic is_bcast_write(input logic [7:0] b);
    return b == BCAST_WR_BYTE;
  endfunction

  // high-speed master code: only the upper five bits are decoded
  function automatic logic is_hs_code(input logic [4:0] top5);
    return top5 == HS_CODE_TOP;
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
`timescale 1ns/1ps
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_q,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_prev, sda_prev, scl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_prev <= 1'b1;
      sda_prev <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_prev <= scl_pipe[STAGES-1];
      sda_prev <= sda_pipe[STAGES-1];
    end
  end

  assign scl_q     = scl_pipe[STAGES-1];
  assign sda_q     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_q & ~scl_prev;
  assign scl_fall  = ~scl_q & scl_prev;
  // R9: data edges while the clock stays high
  assign start_det = scl_q & scl_prev & sda_prev & ~sda_q;
  assign stop_det  = scl_q & scl_prev & ~sda_prev & sda_q;

endmodule

// File: rtl/i2c_link_ctrl.sv
`timescale 1ns/1ps
module i2c_link_ctrl
  import dac_i2c_pkg::*;
#(
  parameter int                 STRAP_W     = 2,
  parameter logic [6-STRAP_W:0] ADDR_PREFIX = 5'b00011
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sda_q,
  input  logic               scl_rise,
  input  logic               scl_fall,
  input  logic               start_det,
  input  logic               stop_det,
  input  logic [STRAP_W-1:0] strap,
  input  logic               clr_hs,
  input  logic [15:0]        rd_word,
  output logic               sda_oe,
  output logic               hs_mode,
  output logic               wr_open,
  output logic               bcast_txn,
  output logic               byte_stb,
  output logic [7:0]         byte_val
);

  function automatic logic own_hit(input logic [6:0] a7, input logic [STRAP_W-1:0] s);
    return a7 == {ADDR_PREFIX, s};
  endfunction

  link_state_e state;
  logic [3:0]  bitcnt;
  logic        in_ack, first_byte, go_send, tx_second, mnack;
  logic [7:0]  shreg, rd_lo;

  // named internal events
  logic active, ack_start, ack_end, own_hit_w, bcast_hit_w, hs_hit_w, ack_now;

  assign active      = (state == LK_RECV) || (state == LK_SEND);
  assign ack_start   = active && scl_fall && !in_ack && (bitcnt == 4'd8);
  assign ack_end     = active && scl_fall && in_ack;
  assign own_hit_w   = own_hit(shreg[7:1], strap);
  assign bcast_hit_w = is_bcast_write(shreg);
  assign hs_hit_w    = is_hs_code(shreg[7:3]);
  assign ack_now     = first_byte ? (own_hit_w || bcast_hit_w) : 1'b1;

  assign wr_open  = ack_start && (state == LK_RECV) && first_byte && ack_now && !shreg[0];
  assign byte_stb = ack_start && (state == LK_RECV) && !first_byte;
  assign byte_val = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= LK_IDLE;
      bitcnt     <= '0;
      in_ack     <= 1'b0;
      first_byte <= 1'b0;
      go_send    <= 1'b0;
      tx_second  <= 1'b0;
      mnack      <= 1'b0;
      shreg      <= '0;
      rd_lo      <= '0;
      sda_oe     <= 1'b0;
      bcast_txn  <= 1'b0;
    end else if (start_det) begin
      state      <= LK_RECV;
      bitcnt     <= '0;
      in_ack     <= 1'b0;
      first_byte <= 1'b1;
      go_send    <= 1'b0;
      tx_second  <= 1'b0;
      bcast_txn  <= 1'b0;
      sda_oe     <= 1'b0;
    end else if (stop_det) begin
      state  <= LK_IDLE;
      in_ack <= 1'b0;
      sda_oe <= 1'b0;
    end else if (active) begin
      if (scl_rise) begin
        if (!in_ack && bitcnt != 4'd8) begin
          bitcnt <= bitcnt + 4'd1;
          if (state == LK_RECV) shreg <= {shreg[6:0], sda_q};
        end
        if (in_ack) mnack <= sda_q;
      end
      if (ack_start) begin
        in_ack <= 1'b1;
        if (state == LK_RECV) begin
          sda_oe <= ack_now;
          if (first_byte) begin
            go_send   <= own_hit_w && shreg[0];
            bcast_txn <= bcast_hit_w;
          end
          if (!ack_now) state <= LK_WAIT;
        end else begin
          sda_oe <= 1'b0;
        end
      end else if (ack_end) begin
        in_ack     <= 1'b0;
        bitcnt     <= '0;
        first_byte <= 1'b0;
        if (state == LK_RECV && go_send) begin
          state     <= LK_SEND;
          shreg     <= rd_word[15:8];
          rd_lo     <= rd_word[7:0];
          sda_oe    <= ~rd_word[15];
          tx_second <= 1'b0;
        end else if (state == LK_SEND && !mnack && !tx_second) begin
          shreg     <= rd_lo;
          sda_oe    <= ~rd_lo[7];
          tx_second <= 1'b1;
        end else if (state == LK_SEND) begin
          state  <= LK_WAIT;
          sda_oe <= 1'b0;
        end else begin
          sda_oe <= 1'b0;
        end
      end else if (scl_fall && state == LK_SEND && !in_ack && bitcnt != 4'd0) begin
        shreg  <= {shreg[6:0], 1'b1};
        sda_oe <= ~shreg[6];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   hs_mode <= 1'b0;
    else if (clr_hs || stop_det)  hs_mode <= 1'b0;
    else if (ack_start && state == LK_RECV && first_byte && hs_hit_w) hs_mode <= 1'b1;
  end

  AST_OE_MOVES_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> $past(scl_fall || start_det || stop_det)); // R10
  AST_QUIET_UNADDRESSED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_WAIT || state == LK_IDLE) |-> !sda_oe); // R4
  AST_HS_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det || clr_hs) |=> !hs_mode); // R3
  AST_NO_BCAST_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (state == LK_SEND) |-> !bcast_txn); // R2

endmodule

// File: rtl/dac_frame_builder.sv
`timescale 1ns/1ps
module dac_frame_builder #(
  parameter int DATA_W  = 16,
  parameter int SEL_BIT = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_open,
  input  logic              bus_break,
  input  logic              byte_stb,
  input  logic [7:0]        byte_val,
  input  logic              bcast_in,
  output logic              frame_valid,
  output logic [DATA_W+7:0] frame_data,
  output logic              frame_bcast
);

  localparam int DATA_BYTES = DATA_W / 8;
  localparam int IDX_W      = $clog2(DATA_BYTES + 1);

  logic [IDX_W-1:0]  idx;     // 0: command byte expected, k: data byte k expected
  logic [7:0]        cmd_q;
  logic [DATA_W-9:0] part_q;
  logic [DATA_W-1:0] data_nxt;
  logic              last_byte;

  assign data_nxt  = {part_q, byte_val};
  assign last_byte = (idx == IDX_W'(DATA_BYTES));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx         <= '0;
      cmd_q       <= '0;
      part_q      <= '0;
      frame_valid <= 1'b0;
      frame_data  <= '0;
      frame_bcast <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (wr_open || bus_break) begin
        idx <= '0;                                 // R8: partial frame dropped
      end else if (byte_stb) begin
        if (idx == '0) begin
          cmd_q <= byte_val;
          idx   <= IDX_W'(1);
        end else if (last_byte) begin
          frame_valid <= 1'b1;
          frame_data  <= {cmd_q, data_nxt};
          frame_bcast <= bcast_in;
          idx         <= cmd_q[SEL_BIT] ? IDX_W'(1) : '0;   // R6
        end else begin
          part_q <= data_nxt[DATA_W-9:0];
          idx    <= idx + IDX_W'(1);
        end
      end
    end
  end

  AST_FRAME_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid); // R5
  AST_FRAME_FROM_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> $past(byte_stb)); // R5
  AST_NO_FRAME_AFTER_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(bus_break) |-> !frame_valid); // R8

endmodule

// File: rtl/dac_i2c_frontend.sv
`timescale 1ns/1ps
module dac_i2c_frontend #(
  parameter int                 STRAP_W     = 2,
  parameter logic [6-STRAP_W:0] ADDR_PREFIX = 5'b00011,
  parameter int                 DATA_W      = 16,
  parameter int                 SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_in,
  input  logic               sda_in,
  output logic               sda_oe,
  input  logic [STRAP_W-1:0] strap,
  input  logic               hs_clear,
  input  logic [15:0]        rd_word,
  output logic               frame_valid,
  output logic [DATA_W+7:0]  frame_data,
  output logic               frame_bcast,
  output logic               hs_mode
);

  logic sda_q, scl_rise, scl_fall, start_det, stop_det;
  logic wr_open, bcast_txn, byte_stb;
  logic [7:0] byte_val;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_in), .sda_in(sda_in),
    .sda_q(sda_q), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_link_ctrl #(.STRAP_W(STRAP_W), .ADDR_PREFIX(ADDR_PREFIX)) u_link (
    .clk(clk), .rst_n(rst_n), .sda_q(sda_q), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det),
    .strap(strap), .clr_hs(hs_clear), .rd_word(rd_word), .sda_oe(sda_oe),
    .hs_mode(hs_mode), .wr_open(wr_open), .bcast_txn(bcast_txn),
    .byte_stb(byte_stb), .byte_val(byte_val)
  );

  dac_frame_builder #(.DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_n), .wr_open(wr_open),
    .bus_break(start_det | stop_det), .byte_stb(byte_stb),
    .byte_val(byte_val), .bcast_in(bcast_txn), .frame_valid(frame_valid),
    .frame_data(frame_data), .frame_bcast(frame_bcast)
  );

endmodule

// File: tb/dac_i2c_frontend_test.sv
`timescale 1ns/1ps
module dac_i2c_frontend_test;

  localparam int Q = 16;   // clocks per SCL quarter period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic [1:0] strap = 2'b10;
  logic hs_clear = 1'b0;
  logic [15:0] rd_word = 16'h0000;
  logic sda_oe, frame_valid, frame_bcast, hs_mode;
  logic [23:0] frame_data;
  wire sda_bus = sda_m & ~sda_oe;

  dac_i2c_frontend uut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_bus), .sda_oe(sda_oe),
    .strap(strap), .hs_clear(hs_clear), .rd_word(rd_word),
    .frame_valid(frame_valid), .frame_data(frame_data),
    .frame_bcast(frame_bcast), .hs_mode(hs_mode)
  );

  int n_cmp = 0, n_bad = 0, oe_high_moves = 0;
  bit done = 1'b0;
  logic oe_prev = 1'b0;
  typedef struct packed { logic b; logic [23:0] d; } exp_t;
  exp_t exp_q[$];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push(input logic b, input logic [23:0] d);
    exp_q.push_back({b, d});
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = (sda_bus == 1'b0);
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit mack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_bus};
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = !mack; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    exp_t e;
    if (rst_n && frame_valid) begin
      if (exp_q.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL R5 unexpected frame actual=%h expected=none", frame_data);
      end else begin
        e = exp_q.pop_front();
        chk("R5 frame/bcast", {7'b0, frame_bcast, frame_data}, {7'b0, e.b, e.d});
      end
    end
  end

  // R10: output enable moves only while the bus clock is low
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m === 1'b1) oe_high_moves++;
    oe_prev = sda_oe;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL R9 watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit a;
    logic [7:0] rb;
    tick(5);
    chk("R9 reset sda_oe", sda_oe, 0);
    chk("R9 reset frame_valid", frame_valid, 0);
    chk("R9 reset hs_mode", hs_mode, 0);
    rst_n = 1'b1;
    tick(10);

    // R1 R5 R6: own address, two standard frames
    bus_start();
    send_byte(8'h1C, a); chk("R1 own address ack", a, 1);
    push(1'b0, 24'h31ABCD);
    send_byte(8'h31, a); chk("R5 cmd ack", a, 1);
    send_byte(8'hAB, a); send_byte(8'hCD, a); chk("R5 lsb ack", a, 1);
    push(1'b0, 24'h123456);
    send_byte(8'h12, a); send_byte(8'h34, a); send_byte(8'h56, a);
    bus_stop(); tick(10);
    chk("R6 standard frames drained", exp_q.size(), 0);

    // R6: sticky two-byte mode
    bus_start(); send_byte(8'h1C, a);
    push(1'b0, 24'h451122); push(1'b0, 24'h453344); push(1'b0, 24'h455566);
    send_byte(8'h45, a); send_byte(8'h11, a); send_byte(8'h22, a);
    send_byte(8'h33, a); send_byte(8'h44, a);
    send_byte(8'h55, a); send_byte(8'h66, a);
    bus_stop(); tick(10);
    chk("R6 sticky frames drained", exp_q.size(), 0);

    // R4: wrong strap, general call, ten-bit prefix
    bus_start(); send_byte(8'h18, a); chk("R4 wrong strap nack", a, 0);
    send_byte(8'h31, a); chk("R4 data after nack ignored", a, 0);
    send_byte(8'h00, a); send_byte(8'h01, a); bus_stop();
    bus_start(); send_byte(8'h00, a); chk("R4 general call nack", a, 0); bus_stop();
    bus_start(); send_byte(8'hF0, a); chk("R4 ten-bit nack", a, 0); bus_stop();
    tick(10);
    chk("R4 no frames from ignored bytes", exp_q.size(), 0);

    // R1: strap change
    strap = 2'b01;
    bus_start(); send_byte(8'h1C, a); chk("R1 old strap nack", a, 0); bus_stop();
    bus_start(); send_byte(8'h1A, a); chk("R1 new strap ack", a, 1);
    push(1'b0, 24'h0A0B0C);
    send_byte(8'h0A, a); send_byte(8'h0B, a); send_byte(8'h0C, a);
    bus_stop(); tick(10);
    strap = 2'b10;

    // R2: broadcast write and read
    bus_start(); send_byte(8'h10, a); chk("R2 broadcast ack", a, 1);
    push(1'b1, 24'h278899);
    send_byte(8'h27, a); send_byte(8'h88, a); send_byte(8'h99, a);
    bus_stop(); tick(10);
    chk("R2 broadcast frame drained", exp_q.size(), 0);
    bus_start(); send_byte(8'h11, a); chk("R2 broadcast read nack", a, 0); bus_stop();

    // R3: master code, repeated start, stop and clear
    bus_start(); send_byte(8'h0B, a); chk("R3 master code nack", a, 0);
    tick(2); chk("R3 hs flag set", hs_mode, 1);
    bus_start(); send_byte(8'h1C, a); chk("R3 address after master code ack", a, 1);
    push(1'b0, 24'h300102);
    send_byte(8'h30, a); send_byte(8'h01, a); send_byte(8'h02, a);
    chk("R3 hs held before stop", hs_mode, 1);
    bus_stop(); tick(4); chk("R3 hs cleared by stop", hs_mode, 0);
    bus_start(); send_byte(8'h0F, a); tick(2); chk("R3 hs set again", hs_mode, 1);
    hs_clear = 1'b1; tick(1); hs_clear = 1'b0; tick(2);
    chk("R3 hs cleared by clear input", hs_mode, 0);
    bus_stop();

    // R8: cut frames
    bus_start(); send_byte(8'h1C, a); send_byte(8'h22, a); send_byte(8'h33, a); bus_stop();
    tick(10); chk("R8 stop drops partial frame", exp_q.size(), 0);
    bus_start(); send_byte(8'h1C, a); send_byte(8'h22, a); send_byte(8'h33, a);
    bus_start(); send_byte(8'h1C, a);
    push(1'b0, 24'h214455);
    send_byte(8'h21, a); send_byte(8'h44, a); send_byte(8'h55, a);
    bus_stop(); tick(10);
    chk("R8 repeated start drops partial frame", exp_q.size(), 0);

    // R7: reads
    rd_word = 16'hA53C;
    bus_start(); send_byte(8'h1D, a); chk("R7 read address ack", a, 1);
    rd_word = 16'h0000;
    recv_byte(rb, 1'b1); chk("R7 read high byte", rb, 8'hA5);
    recv_byte(rb, 1'b1); chk("R7 read low byte", rb, 8'h3C);
    tick(2); chk("R7 line released after two bytes", sda_oe, 0);
    bus_stop();
    rd_word = 16'h5AC3;
    bus_start(); send_byte(8'h1D, a);
    recv_byte(rb, 1'b1); chk("R7 read high byte 2", rb, 8'h5A);
    recv_byte(rb, 1'b1); chk("R7 read low byte 2", rb, 8'hC3);
    bus_stop();

    tick(20);
    chk("R5 scoreboard empty", exp_q.size(), 0);
    chk("R10 no oe change while SCL high", oe_high_moves, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule